// File: doc/BRIEF.md
# Lane Deskew Calibration Detector

This block watches the deserialized data of a single serial lane and recognises the burst a transmitter sends so that the receiver can line up the timing of its lanes. The burst is sixteen 1 bits followed by a long run of alternating bits. The lane arrives as 16-bit words, one per valid cycle. The position of the burst inside those words is not known beforehand, so the detector looks for the leading run of ones at every possible bit offset.

Once the run of ones is found, the detector records where it sits in the word and then follows the alternating run at that offset. After a few whole words of clean alternation it raises a calibration flag, which tells the lane delay logic that it may adjust. It keeps the flag up while the alternation continues and drops it on the first word that breaks the pattern. Cycles that carry no valid word are skipped entirely.

Top module: `lane_deskew_detect`

## Requirements
- R1: A synchronous active-high reset clears `cal_on` to 0 and `cal_offset` to 0, and the outputs read that way on the first edge after reset is sampled high.
- R2: Bit 0 of `in_word` is the earliest bit on the lane. The search window puts the previous valid word in bits 0 to 15 and the current one in bits 16 to 31. When window bits k to k+15 are all 1 and bit k+16 is 0, for any k from 0 to 15, the detector starts tracking and `cal_offset` equals k from the edge that took the current word.
- R3: While tracking at offset k, the expected word has bit i set exactly when i+k is odd (0xAAAA for even k, 0x5555 for odd k). `cal_on` rises on the edge that takes the fourth consecutive valid word equal to that pattern, and not before.
- R4: While `cal_on` is high, each valid word equal to the expected pattern keeps `cal_on` high and `cal_offset` unchanged.
- R5: While `cal_on` is high, a valid word that differs from the expected pattern clears `cal_on` on the edge that takes it.
- R6: A cycle with `in_valid` low changes neither output, and does not advance or clear the count of matching words, whatever `in_word` holds.
- R7: A valid word that breaks the pattern before the fourth match sends the detector back to searching, so later alternating words alone do not raise `cal_on` and `cal_offset` keeps its value.
- R8: A run of only fifteen 1 bits followed by a 0 is not taken as a burst: `cal_offset` stays as it was and `cal_on` stays low.
- R9: After a burst is lost, a new burst at a different offset is found, `cal_offset` takes the new offset, and `cal_on` rises after four matching words at that offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane word clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | `in_word` carries a lane word this cycle |
| in_word | input | 16 | Deserialized lane bits, bit 0 earliest |
| cal_on | output | 1 | Calibration burst present and locked |
| cal_offset | output | 4 | Bit offset of the leading run of ones in the word |

## Verification
The properties assume that `in_word` holds a steady value whenever `in_valid` is high at an edge, and that reset is held for at least one edge before any stimulus. They also assume that a burst cannot start and lock within the same word, which follows from a run of sixteen ones needing at least one following word to close. The bench drives all inputs on the falling edge and builds every burst from the offset alone: a word of trailing ones, a word that finishes the run and starts the alternation, then pure alternating words. Idle cycles carry data that would break the pattern if it were counted.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

    localparam int LANE_W  = 16;
    localparam int OFF_W   = $clog2(LANE_W);
    localparam int WIN_W   = 2 * LANE_W;
    localparam int MIN_RUN = 4;

    typedef logic [LANE_W-1:0] lane_word_t;
    typedef logic [OFF_W-1:0]  lane_off_t;

    typedef enum logic [1:0] {
        ST_SEARCH,
        ST_TRACK,
        ST_LOCKED
    } det_state_e;

    typedef struct packed {
        logic      hit;
        lane_off_t off;
    } scan_res_t;

    // Word expected during the alternating run when the leading ones
    // started at bit offset off: bit i is set when i+off is odd.
    function automatic lane_word_t alt_word(input lane_off_t off);
        lane_word_t w;
        for (int i = 0; i < LANE_W; i++) begin
            w[i] = ((i % 2) == 1) ^ off[0];
        end
        return w;
    endfunction

endpackage

// File: rtl/preamble_scan.sv
module preamble_scan
    import deskew_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  lane_word_t in_word,
    output scan_res_t  res
);

    lane_word_t          prev_q;
    logic [WIN_W-1:0]    win;
    logic [LANE_W-1:0]   hit_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else if (in_valid) begin
            prev_q <= in_word;
        end
    end

    assign win = {in_word, prev_q};

    // One comparator per candidate offset: a full run of ones then a zero.
    for (genvar k = 0; k < LANE_W; k++) begin : g_off
        assign hit_vec[k] = (&win[k+LANE_W-1:k]) & ~win[k+LANE_W];
    end

    // Lowest offset wins; at most one can hit inside a 2-word window.
    always_comb begin
        res = '0;
        for (int k = LANE_W - 1; k >= 0; k--) begin
            if (hit_vec[k]) begin
                res.hit = 1'b1;
                res.off = lane_off_t'(k);
            end
        end
    end

endmodule

// File: rtl/alt_compare.sv
module alt_compare
    import deskew_pkg::*;
(
    input  lane_word_t in_word,
    input  lane_off_t  off,
    output logic       match
);

    lane_word_t expect_w;

    assign expect_w = alt_word(off);
    assign match    = (in_word == expect_w);

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import deskew_pkg::*;
#(
    parameter int MIN_WORDS = MIN_RUN
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  scan_res_t scan,
    input  logic      match,
    output lane_off_t off_q,
    output logic      locked
);

    localparam int CNT_W = (MIN_WORDS > 1) ? $clog2(MIN_WORDS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_WORDS - 1);

    det_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SEARCH;
            cnt_q   <= '0;
            off_q   <= '0;
        end else if (in_valid) begin
            if (scan.hit) begin
                state_q <= ST_TRACK;
                cnt_q   <= '0;
                off_q   <= scan.off;
            end else begin
                case (state_q)
                    ST_TRACK: begin
                        if (!match) begin
                            state_q <= ST_SEARCH;
                            cnt_q   <= '0;
                        end else if (cnt_q == LAST) begin
                            state_q <= ST_LOCKED;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_LOCKED: begin
                        if (!match) begin
                            state_q <= ST_SEARCH;
                        end
                    end
                    default: begin
                        cnt_q <= '0;
                    end
                endcase
            end
        end
    end

    assign locked = (state_q == ST_LOCKED);

endmodule

// File: rtl/lane_deskew_detect.sv
module lane_deskew_detect
    import deskew_pkg::*;
#(
    parameter int MIN_WORDS = MIN_RUN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [LANE_W-1:0] in_word,
    output logic              cal_on,
    output logic [OFF_W-1:0]  cal_offset
);

    scan_res_t scan;
    lane_off_t off_q;
    logic      match;
    logic      locked;

    preamble_scan u_scan (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_word  (in_word),
        .res      (scan)
    );

    alt_compare u_cmp (
        .in_word (in_word),
        .off     (off_q),
        .match   (match)
    );

    lock_fsm #(
        .MIN_WORDS (MIN_WORDS)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .scan     (scan),
        .match    (match),
        .off_q    (off_q),
        .locked   (locked)
    );

    assign cal_on     = locked;
    assign cal_offset = off_q;

endmodule

// File: rtl/deskew_checker.sv
module deskew_checker
    import deskew_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [LANE_W-1:0] in_word,
    input logic              cal_on,
    input logic [OFF_W-1:0]  cal_offset
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!cal_on && cal_offset == '0));

    p_offset_steady_r2: assert property (@(posedge clk) disable iff (rst)
        cal_on |-> $stable(cal_offset));

    p_rise_on_match_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(cal_on) |-> ($past(in_valid) && $past(in_word) == alt_word(cal_offset)));

    p_keep_on_match_r4: assert property (@(posedge clk) disable iff (rst)
        (cal_on && in_valid && in_word == alt_word(cal_offset)) |=> cal_on);

    p_drop_on_break_r5: assert property (@(posedge clk) disable iff (rst)
        (cal_on && in_valid && in_word != alt_word(cal_offset)) |=> !cal_on);

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(cal_on) && $stable(cal_offset)));

endmodule

bind lane_deskew_detect deskew_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_word    (in_word),
    .cal_on     (cal_on),
    .cal_offset (cal_offset)
);

// File: tb/sim_lane_deskew_detect.sv
`timescale 1ns/1ps
module sim_lane_deskew_detect;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        cal_on;
    logic [3:0]  cal_offset;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    lane_deskew_detect u0 (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_word    (in_word),
        .cal_on     (cal_on),
        .cal_offset (cal_offset)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] w, input logic v);
        @(negedge clk);
        in_valid = v;
        in_word  = w;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [15:0] alt_of(input int k);
        return (k % 2 == 0) ? 16'hAAAA : 16'h5555;
    endfunction

    function automatic logic [15:0] head_of(input int k);
        return 16'hFFFF << k;
    endfunction

    function automatic logic [15:0] tail_of(input int k);
        logic [15:0] low;
        low = (16'h1 << k) - 16'h1;
        return low | (alt_of(k) & ~low);
    endfunction

    // Starts a burst at offset k and checks the recorded offset.
    task automatic start_burst(input int k, input string req);
        push(16'h0000, 1'b1);
        push(16'h0000, 1'b1);
        push(head_of(k), 1'b1);
        push(tail_of(k), 1'b1);
        chk(req, cal_offset, k);
    endtask

    task automatic finish(input bit wd);
        if (!done) begin
            done = 1'b1;
            if (wd) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=expired expected=finished");
            end
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        finish(1'b1);
    end

    initial begin
        // R1: outputs held clear under reset
        repeat (2) @(posedge clk);
        #1;
        chk("R1 cal_on", cal_on, 0);
        chk("R1 cal_offset", cal_offset, 0);
        @(negedge clk);
        rst = 1'b0;

        // R2..R6 across every offset
        for (int k = 0; k < 16; k++) begin
            start_burst(k, "R2 offset");
            chk("R2 no early lock", cal_on, 0);
            for (int j = 1; j <= 4; j++) begin
                push(alt_of(k), 1'b1);
                chk("R3 lock on fourth", cal_on, (j == 4) ? 1 : 0);
                if (j == 2) begin
                    push(~alt_of(k), 1'b0);
                    chk("R6 idle during track", cal_on, 0);
                end
            end
            push(16'hFFFF, 1'b0);
            push(16'h0000, 1'b0);
            chk("R6 idle keeps on", cal_on, 1);
            chk("R6 idle keeps offset", cal_offset, k);
            push(alt_of(k), 1'b1);
            chk("R4 stays on", cal_on, 1);
            chk("R4 offset kept", cal_offset, k);
            push(~alt_of(k), 1'b1);
            chk("R5 drop on break", cal_on, 0);
        end

        // R7: break before the fourth match
        start_burst(5, "R7 offset");
        push(alt_of(5), 1'b1);
        push(alt_of(5), 1'b1);
        push(16'h0000, 1'b1);
        chk("R7 still off", cal_on, 0);
        for (int j = 0; j < 5; j++) begin
            push(alt_of(5), 1'b1);
            chk("R7 no lock after restart", cal_on, 0);
        end
        chk("R7 offset kept", cal_offset, 5);

        // R8: fifteen ones then a zero
        push(16'h0000, 1'b1);
        push(16'h7FFF, 1'b1);
        for (int j = 0; j < 5; j++) begin
            push(16'hAAAA, 1'b1);
            chk("R8 no lock", cal_on, 0);
        end
        chk("R8 offset unchanged", cal_offset, 5);

        // R9: lose a burst and find a new one at another offset
        start_burst(3, "R9 first offset");
        for (int j = 0; j < 4; j++) push(alt_of(3), 1'b1);
        chk("R9 first lock", cal_on, 1);
        push(head_of(12), 1'b1);
        chk("R9 lost", cal_on, 0);
        push(tail_of(12), 1'b1);
        chk("R9 new offset", cal_offset, 12);
        for (int j = 1; j <= 4; j++) begin
            push(alt_of(12), 1'b1);
            chk("R9 relock", cal_on, (j == 4) ? 1 : 0);
        end

        // R1: reset while locked
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 reset clears on", cal_on, 0);
        chk("R1 reset clears offset", cal_offset, 0);
        @(negedge clk);
        rst = 1'b0;
        push(alt_of(12), 1'b1);
        chk("R1 no lock after reset", cal_on, 0);

        finish(1'b0);
    end

endmodule